// File: doc/BRIEF.md
# Successive-Approximation Converter Switch Sequencer

This block is the digital controller for a 10-bit charge-redistribution successive-approximation converter. The converter's capacitor array is a cascoded binary-weighted array. Its most significant decision uses split-junction switching. A one-cycle start request begins a conversion. The controller then steps through a clear phase, a sampling phase, one MSB decision cycle and nine further decision cycles. In every cycle it drives the array's discharge switch, three sampling switches and one junction switch, plus a two-bit bottom-plate select for each capacitor.

Each decision cycle ends on a clock edge that captures the comparator output. A high comparator output means the array node sits above mid-scale, and the bit is then resolved as 0. When the last decision is taken, the ten result bits appear together on the code output, along with a one-cycle done strobe. All switch and plate outputs come straight from flip-flops. The next-state values of the one-hot phase register feed those flip-flops.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is active, and after it, all five switch controls are 0, all plate selects are ground, done is 0 and code is 0.
- R2: start is taken only while the controller is idle, which includes the done cycle. A start seen during a conversion has no effect, including a start seen on the edge that ends the last decision.
- R3: The clock edge that takes start begins 4 clear cycles. In these cycles sw_rst, sw_smp2 and sw_smp3 are 1, and sw_smp1 and sw_jct are 0.
- R4: 6 sampling cycles follow. In these cycles sw_smp1, sw_smp2 and sw_smp3 are 1, and sw_rst and sw_jct are 0.
- R5: The next cycle is the MSB decision cycle. In it only sw_smp3 is 1. Capacitor 9 (the top) floats, capacitor 8 selects the reference, and all other capacitors select ground.
- R6: In the nine cycles that decide bits 8 down to 0, only sw_jct is 1.
- R7: Each result bit is the inverse of cmp_hi, sampled on the edge that ends its decision cycle. cmp_hi has no effect in clear, sampling or idle cycles.
- R8: In the cycle that decides bit b (b < 9), capacitor b selects the reference. Each capacitor above b selects the reference if its bit was resolved to 1 and ground if it was resolved to 0. Each capacitor below b selects ground.
- R9: A plate select is two bits: 00 ground, 01 reference, 10 float. The value 11 never appears. Float appears only on capacitor 9 during the MSB cycle.
- R10: done is high for exactly one cycle, 20 cycles after the edge that took start. code changes only on that edge and then holds its value.
- R11: In idle cycles, including the done cycle, all switches are 0 and all plates select ground.
- R12: A start in the done cycle begins a new conversion right away, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request |
| cmp_hi | input | 1 | Comparator output: array node above mid-scale |
| sw_rst | output | 1 | Array discharge switch |
| sw_smp1 | output | 1 | Input sampling switch 1 |
| sw_smp2 | output | 1 | Sampling switch 2 |
| sw_smp3 | output | 1 | Sampling switch 3 |
| sw_jct | output | 1 | Junction switch 4 |
| plate | output | 20 | Bottom-plate select, 2 bits per capacitor, capacitor k at bits [2k+1:2k] |
| done | output | 1 | One-cycle strobe that marks a new result |
| code | output | 10 | Converted result |

## Verification
Two events can land in the same cycle. The first is the edge that captures the final decision and returns the controller to idle. The second is a new start request arriving on that same edge, or one cycle later, in the done cycle. The bench provokes both cases. It sometimes raises start during the last decision cycle, and then expects the following cycle to be idle. It sometimes raises start in the done cycle, and then expects clear-phase switch states on the very next cycle with no idle gap. Both cases are judged against a per-cycle table of switch states. A comparator model answers from the plate selects it observes, and the bench also checks the resulting code.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [4:0] {
    PH_IDLE = 5'b00001,
    PH_CLR  = 5'b00010,
    PH_SMP  = 5'b00100,
    PH_MSB  = 5'b01000,
    PH_BIT  = 5'b10000
  } phase_e;

  typedef enum logic [1:0] {
    PL_GND = 2'b00,
    PL_REF = 2'b01,
    PL_FLT = 2'b10
  } plate_e;

  typedef struct packed {
    logic rst;
    logic smp1;
    logic smp2;
    logic smp3;
    logic jct;
  } sw_t;

  // switch states held during each phase
  function automatic sw_t sw_table(phase_e ph);
    sw_t s;
    s = '0;
    unique case (ph)
      PH_CLR: begin s.rst = 1'b1; s.smp2 = 1'b1; s.smp3 = 1'b1; end
      PH_SMP: begin s.smp1 = 1'b1; s.smp2 = 1'b1; s.smp3 = 1'b1; end
      PH_MSB: s.smp3 = 1'b1;
      PH_BIT: s.jct = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction

  // bottom-plate select of capacitor k while bit bit_i is being decided
  function automatic plate_e plate_sel(phase_e ph, int unsigned bit_i,
                                       int unsigned k, logic trial_k,
                                       int unsigned top);
    if (ph == PH_MSB) begin
      if (k == top)     return PL_FLT;
      if (k == top - 1) return PL_REF;
      return PL_GND;
    end
    if (ph == PH_BIT) begin
      if (k > bit_i)  return trial_k ? PL_REF : PL_GND;
      if (k == bit_i) return PL_REF;
    end
    return PL_GND;
  endfunction

endpackage

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
  import sar_seq_pkg::*;
#(
  parameter int NBITS   = 10,
  parameter int RST_CYC = 4,
  parameter int SMP_CYC = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output phase_e                   phase_q,
  output phase_e                   phase_d,
  output logic [$clog2(NBITS)-1:0] bit_q,
  output logic [$clog2(NBITS)-1:0] bit_d,
  output logic                     accept,
  output logic                     conv_end
);
  localparam int BW   = $clog2(NBITS);
  localparam int CMAX = (RST_CYC > SMP_CYC) ? RST_CYC : SMP_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_CLR;
        cnt_d   = CW'(RST_CYC - 1);
      end
      PH_CLR: if (cnt_q == '0) begin
        phase_d = PH_SMP;
        cnt_d   = CW'(SMP_CYC - 1);
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
      PH_SMP: if (cnt_q == '0) begin
        phase_d = PH_MSB;
        bit_d   = BW'(NBITS - 1);
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
      PH_MSB: begin
        phase_d = PH_BIT;
        bit_d   = BW'(NBITS - 2);
      end
      PH_BIT: if (bit_q == '0) phase_d = PH_IDLE;
              else bit_d = bit_q - BW'(1);
      default: phase_d = PH_IDLE;
    endcase
  end

  assign accept   = (phase_q == PH_IDLE) && start;
  assign conv_end = (phase_q == PH_BIT) && (bit_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     conv_end,
  input  phase_e                   phase_q,
  input  logic [$clog2(NBITS)-1:0] bit_q,
  input  logic                     cmp_hi,
  output logic [NBITS-1:0]         trial_d,
  output logic [NBITS-1:0]         code,
  output logic                     done
);
  logic [NBITS-1:0] trial_q;
  logic             decide;

  assign decide = (phase_q == PH_MSB) || (phase_q == PH_BIT);

  always_comb begin
    trial_d = trial_q;
    if (accept)      trial_d = '0;
    else if (decide) trial_d[bit_q] = ~cmp_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      code    <= '0;
      done    <= 1'b0;
    end else begin
      trial_q <= trial_d;
      done    <= conv_end;
      if (conv_end) code <= trial_d;
    end
  end
endmodule

// File: rtl/sar_switch_dec.sv
module sar_switch_dec
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  phase_e                   phase_d,
  input  logic [$clog2(NBITS)-1:0] bit_d,
  input  logic [NBITS-1:0]         trial_d,
  output sw_t                      sw,
  output logic [2*NBITS-1:0]       plate
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw <= '0;
    else        sw <= sw_table(phase_d);
  end

  for (genvar k = 0; k < NBITS; k++) begin : g_cap
    plate_e pl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pl_q <= PL_GND;
      else pl_q <= plate_sel(phase_d, 32'(bit_d), k, trial_d[k], NBITS - 1);
    end
    assign plate[2*k +: 2] = pl_q;
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int NBITS   = 10,
  parameter int RST_CYC = 4,
  parameter int SMP_CYC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cmp_hi,
  output logic               sw_rst,
  output logic               sw_smp1,
  output logic               sw_smp2,
  output logic               sw_smp3,
  output logic               sw_jct,
  output logic [2*NBITS-1:0] plate,
  output logic               done,
  output logic [NBITS-1:0]   code
);
  localparam int BW = $clog2(NBITS);

  phase_e           phase_q, phase_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic             accept;    // start taken this edge
  logic             conv_end;  // last decision captured this edge
  logic [NBITS-1:0] trial_d;
  sw_t              sw;

  sar_phase_ctrl #(.NBITS(NBITS), .RST_CYC(RST_CYC), .SMP_CYC(SMP_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .start(start),
    .phase_q(phase_q), .phase_d(phase_d), .bit_q(bit_q), .bit_d(bit_d),
    .accept(accept), .conv_end(conv_end)
  );

  sar_bit_reg #(.NBITS(NBITS)) u_bits (
    .clk(clk), .rst_n(rst_n), .accept(accept), .conv_end(conv_end),
    .phase_q(phase_q), .bit_q(bit_q), .cmp_hi(cmp_hi),
    .trial_d(trial_d), .code(code), .done(done)
  );

  sar_switch_dec #(.NBITS(NBITS)) u_dec (
    .clk(clk), .rst_n(rst_n), .phase_d(phase_d), .bit_d(bit_d),
    .trial_d(trial_d), .sw(sw), .plate(plate)
  );

  assign sw_rst  = sw.rst;
  assign sw_smp1 = sw.smp1;
  assign sw_smp2 = sw.smp2;
  assign sw_smp3 = sw.smp3;
  assign sw_jct  = sw.jct;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NBITS = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               sw_rst,
  input logic               sw_smp1,
  input logic               sw_smp2,
  input logic               sw_smp3,
  input logic               sw_jct,
  input logic [2*NBITS-1:0] plate,
  input logic               done,
  input logic [NBITS-1:0]   code,
  input logic               accept,
  input logic               conv_end
);
  logic bad_code;
  logic any_float;

  always_comb begin
    bad_code  = 1'b0;
    any_float = 1'b0;
    for (int k = 0; k < NBITS; k++) begin
      if (plate[2*k +: 2] == 2'b11) bad_code = 1'b1;
      if (plate[2*k +: 2] == 2'b10) any_float = 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(code)); // R10
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> done); // R10
  AST_NO_PLATE_11: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_code); // R9
  AST_FLOAT_IN_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    any_float |-> (sw_smp3 && !sw_jct && !sw_smp1 && !sw_rst)); // R5
  AST_JCT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_jct |-> !(sw_rst || sw_smp1 || sw_smp2 || sw_smp3)); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sw_jct) |=> !sw_rst); // R2
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (sw_rst && sw_smp2 && sw_smp3 && !sw_smp1)); // R3
endmodule

bind sar_seq_ctrl sar_seq_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .sw_rst(sw_rst), .sw_smp1(sw_smp1), .sw_smp2(sw_smp2), .sw_smp3(sw_smp3),
  .sw_jct(sw_jct), .plate(plate), .done(done), .code(code),
  .accept(accept), .conv_end(conv_end)
);

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;
  localparam int N = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           cmp_hi = 1'b0;
  logic           sw_rst, sw_smp1, sw_smp2, sw_smp3, sw_jct;
  logic [2*N-1:0] plate;
  logic           done;
  logic [N-1:0]   code;

  int checks = 0;
  int errors = 0;
  bit pre_started = 1'b0;
  logic [N-1:0] last_code = '0;

  sar_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi),
    .sw_rst(sw_rst), .sw_smp1(sw_smp1), .sw_smp2(sw_smp2), .sw_smp3(sw_smp3),
    .sw_jct(sw_jct), .plate(plate), .done(done), .code(code)
  );

  always #5 clk = ~clk;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] sw_obs();
    return {sw_rst, sw_smp1, sw_smp2, sw_smp3, sw_jct};
  endfunction

  // expected {rst,smp1,smp2,smp3,jct} in conversion cycle c
  function automatic logic [4:0] exp_sw(int c);
    if (c < 4)   return 5'b10110;
    if (c < 10)  return 5'b01110;
    if (c == 10) return 5'b00010;
    return 5'b00001;
  endfunction

  function automatic logic [2*N-1:0] exp_plate(int c, logic [N-1:0] v);
    logic [2*N-1:0] p;
    int b;
    p = '0;
    if (c == 10) begin
      p[2*(N-1) +: 2] = 2'b10;
      p[2*(N-2) +: 2] = 2'b01;
    end else if (c > 10) begin
      b = 19 - c;
      for (int k = 0; k < N; k++) begin
        if (k > b)       p[2*k +: 2] = v[k] ? 2'b01 : 2'b00;
        else if (k == b) p[2*k +: 2] = 2'b01;
      end
    end
    return p;
  endfunction

  // comparator model: trial level read from plate selects
  function automatic int trial_level();
    int t;
    if (plate[2*(N-1) +: 2] == 2'b10) return 1 << (N - 1);
    t = 0;
    for (int k = 0; k < N; k++) if (plate[2*k +: 2] == 2'b01) t += (1 << k);
    return t;
  endfunction

  task automatic run_conv(int vin, bit chain, bit poke);
    if (!pre_started) begin
      @(negedge clk);
      start = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 20; c++) begin
      chk(sw_obs() == exp_sw(c),
          (c < 4) ? "R3 clear" : (c < 10) ? "R4 sample" : (c == 10) ? "R5 msb" : "R6 bit",
          32'(sw_obs()), 32'(exp_sw(c)));
      chk(plate == exp_plate(c, N'(vin)), (c == 10) ? "R5 R9 plates" : "R8 R9 plates",
          32'(plate), 32'(exp_plate(c, N'(vin))));
      chk(!done && code == last_code, "R10 hold", {done, 22'(code)}, {1'b0, 22'(last_code)});
      if (c >= 10) cmp_hi = (vin < trial_level());
      else         cmp_hi = 1'($urandom % 2);   // R7 ignored outside decisions
      start = poke && (c == 7 || c == 15 || c == 19); // R2 busy starts
      @(negedge clk);
    end
    chk(done == 1'b1, "R10 done", 32'(done), 1);
    chk(code == N'(vin), "R7 code", 32'(code), 32'(vin));
    chk(sw_obs() == 5'b0 && plate == '0, "R11 done-cycle idle", 32'(plate), 0);
    last_code = N'(vin);
    cmp_hi = 1'($urandom % 2);
    start = chain;
    pre_started = chain;
    if (!chain) begin
      @(negedge clk);
      chk(!done && sw_obs() == 5'b0 && plate == '0, "R2 R11 idle after done",
          {sw_obs(), 20'(plate)}, 0);
      chk(code == N'(vin), "R10 code held", 32'(code), 32'(vin));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    chk(sw_obs() == 5'b0 && plate == '0 && !done && code == '0, "R1 in reset",
        {sw_obs(), 20'(plate)}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sw_obs() == 5'b0 && plate == '0 && !done && code == '0, "R1 after reset",
        {sw_obs(), 20'(plate)}, 0);
    // directed corners
    run_conv(0, 0, 0);
    run_conv(1023, 0, 1);   // R2 start poked while busy and on the final edge
    run_conv(512, 1, 0);    // R12 restart in done cycle
    run_conv(511, 1, 1);
    run_conv(1, 0, 0);
    run_conv(682, 0, 0);
    // constrained random
    for (int i = 0; i < 30; i++)
      run_conv(int'($urandom % 1024), 1'($urandom % 2), 1'($urandom % 2));
    if (pre_started) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(sw_obs() == 5'b10110, "R12 back-to-back clear", 32'(sw_obs()), 32'h16);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule